// File: doc/BRIEF.md
# Parallel ATA PIO Cycle Sequencer

This block turns one host request into a single programmed-I/O transfer on a parallel ATA bus. A request names a target register through a five-bit select, says whether the transfer is a read or a write, and says whether it uses the 8-bit register timing set or the 16-bit data-port timing set. The block then drives the two chip selects, the three address lines and the active-low read and write strobes. On writes it drives the data bus, and on reads it captures the bus.

Every phase is counted in clocks. The phases are address setup, strobe active, and recovery. Software computes the counts and presents them on the timing inputs. The block samples these counts, together with the transfer mode and the ready-check enable, when it accepts a request. While ready checking is on, a device can stretch the active phase by holding IORDY low. A counter bounds that stretch, and a flag reports a device that never becomes ready. A one-cycle completion pulse marks the end of each cycle. Read data stays on its output until the next read completes.

Top module: `ata_pio_seq`

## Requirements
- R1: Out of reset, and whenever `busy` is low, both chip selects and both strobes are high, `ata_da` is 0, `dd_oe` is low, and `done` is low.
- R2: While `busy` is high, `ata_da` equals `req_sel[4:2]`, `ata_cs1_n` equals `req_sel[1]` and `ata_cs0_n` equals `req_sel[0]`, all as captured at acceptance. They stay unchanged until the cycle ends.
- R3: The first max(`t_setup`,1) busy cycles present the address with both strobes high.
- R4: With ready checking off, the strobe stays low for exactly max(active,1) cycles, and IORDY has no effect. Active is `t_act8` when `req_reg8`=1 and `t_act16` when `req_reg8`=0.
- R5: A read lowers only `ata_dior_n` and a write lowers only `ata_diow_n`. The two strobes are never low together.
- R6: For a read, `rd_data` takes the `dd_in` value sampled at the clock edge that ends the last strobe-low cycle, which is the strobe's rising edge. After a write, `rd_data` keeps its previous value.
- R7: During a write, `dd_oe` is high and `dd_out` carries the write data for every strobe-low cycle and for H cycles after the strobe rises. H is 3 when `pio_mode`=0, 2 when `pio_mode` is 1 or 2, and 1 otherwise. `dd_oe` is never high during a read.
- R8: With `iordy_en`=1, the strobe is released at the first strobe-low count n where n ≥ max(active,1), n ≥ IORDY_FIRST, and IORDY is high in that cycle.
- R9: With `iordy_en`=1, the strobe is released at count IORDY_LIMIT even if IORDY is still low. `timeout` rises in the cycle after the strobe rises and stays high until the next request is accepted. `timeout` stays low when IORDY was high at release.
- R10: After the strobe rises, the address is held with both strobes high for max(cycle − n, recovery, 1) cycles, where n is the actual strobe-low count. For a write the count is also at least H. Cycle and recovery come from the set chosen by `req_reg8`.
- R11: A request is accepted only when `busy` is low, and a `req_valid` raised while busy has no effect. `done` is high for exactly one cycle, the first idle cycle after recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg8 | input | 1 | 1 = 8-bit register timing set, 0 = 16-bit data timing set |
| req_sel | input | 5 | Target select {A2,A1,A0,CS1 active-low,CS0 active-low} |
| req_wdata | input | DW | Write data |
| iordy_en | input | 1 | Allow IORDY to stretch the active phase |
| pio_mode | input | 3 | PIO mode, picks the write data hold |
| t_setup | input | TW | Setup clocks |
| t_act16 | input | TW | Active clocks, data port |
| t_rec16 | input | TW | Recovery clocks, data port |
| t_cyc16 | input | TW | Full-cycle clocks, data port |
| t_act8 | input | TW | Active clocks, register access |
| t_rec8 | input | TW | Recovery clocks, register access |
| t_cyc8 | input | TW | Full-cycle clocks, register access |
| busy | output | 1 | A bus cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Last cycle ended without IORDY |
| rd_data | output | DW | Data captured by the last read |
| ata_cs0_n | output | 1 | Chip select 0, active low |
| ata_cs1_n | output | 1 | Chip select 1, active low |
| ata_da | output | 3 | Device address lines |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| dd_out | output | DW | Data bus drive value |
| dd_oe | output | 1 | Data bus drive enable |
| dd_in | input | DW | Data bus sampled value |
| iordy | input | 1 | Device ready |

## Verification
The hardest case to reach from the ports is read capture at the exact strobe edge while IORDY stretches the active phase. Here the capture cycle depends on when the device reports ready. The bench drives IORDY low until a chosen strobe-low count. It also presents the real read value on `dd_in` only during the one cycle that ends the strobe, and drives its complement in every other cycle. A capture one cycle early or one cycle late therefore returns the wrong word. Further runs cover IORDY high before the first legal sample point, IORDY never rising, and a request pulsed in the middle of a busy cycle.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_RECOV  = 2'd3
    } phase_e;

    // Field order is decoded by the device: {A2,A1,A0,CS1 active-low,CS0 active-low}
    typedef struct packed {
        logic [2:0] da;
        logic       cs1_n;
        logic       cs0_n;
    } regsel_t;

    localparam regsel_t SEL_IDLE = '{da: 3'd0, cs1_n: 1'b1, cs0_n: 1'b1};

    // Clocks the write data stays driven after the write strobe rises
    function automatic logic [1:0] wr_hold_clks(input logic [2:0] mode);
        if (mode == 3'd0)      return 2'd3;
        else if (mode <= 3'd2) return 2'd2;
        else                   return 2'd1;
    endfunction

endpackage

// File: rtl/ata_pio_timing_sel.sv
module ata_pio_timing_sel
    import ata_pio_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          reg8,
    input  logic [2:0]    pio_mode,
    input  logic [TW-1:0] t_setup,
    input  logic [TW-1:0] t_act16,
    input  logic [TW-1:0] t_rec16,
    input  logic [TW-1:0] t_cyc16,
    input  logic [TW-1:0] t_act8,
    input  logic [TW-1:0] t_rec8,
    input  logic [TW-1:0] t_cyc8,
    output logic [TW-1:0] setup_len,
    output logic [TW-1:0] act_len,
    output logic [TW-1:0] rec_len,
    output logic [TW-1:0] cyc_len,
    output logic [1:0]    hold_len
);

    localparam logic [TW-1:0] ONE = TW'(1);

    function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    logic [TW-1:0] act_pick, rec_pick, cyc_pick;

    always_comb begin
        act_pick = reg8 ? t_act8 : t_act16;
        rec_pick = reg8 ? t_rec8 : t_rec16;
        cyc_pick = reg8 ? t_cyc8 : t_cyc16;
    end

    assign setup_len = at_least_one(t_setup);
    assign act_len   = at_least_one(act_pick);
    assign rec_len   = at_least_one(rec_pick);
    assign cyc_len   = cyc_pick;
    assign hold_len  = wr_hold_clks(pio_mode);

endmodule

// File: rtl/ata_pio_phase_fsm.sv
module ata_pio_phase_fsm
    import ata_pio_pkg::*;
#(
    parameter int TW    = 8,
    parameter int FIRST = 2,
    parameter int LIMIT = 40,
    parameter int CW    = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          write_in,
    input  logic          iordy_en_in,
    input  logic          iordy,
    input  logic [TW-1:0] setup_len,
    input  logic [TW-1:0] act_len,
    input  logic [TW-1:0] rec_len,
    input  logic [TW-1:0] cyc_len,
    input  logic [1:0]    hold_len,
    output phase_e        phase,
    output logic          hold_on,
    output logic          strobe_rise,
    output logic          done,
    output logic          timeout
);

    localparam logic [CW-1:0] FIRST_C = CW'(FIRST);
    localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

    logic [CW-1:0] cnt;
    logic [TW-1:0] s_q, a_q, r_q, c_q;
    logic [1:0]    h_q;
    logic          wr_q, en_q;
    logic [CW-1:0] rec_target;
    logic [CW-1:0] gap, rec_calc;
    logic          act_exit;

    // Strobe release: minimum active met, then ready, limit, or no checking
    always_comb begin
        act_exit = (phase == PH_ACTIVE) && (cnt >= CW'(a_q)) &&
                   (!en_q || (iordy && cnt >= FIRST_C) || cnt >= LIMIT_C);
    end

    // Recovery length from the real active count
    always_comb begin
        gap      = (CW'(c_q) > cnt) ? (CW'(c_q) - cnt) : '0;
        rec_calc = (gap > CW'(r_q)) ? gap : CW'(r_q);
        if (wr_q && CW'(h_q) > rec_calc) rec_calc = CW'(h_q);
    end

    assign strobe_rise = act_exit;
    assign hold_on     = (phase == PH_RECOV) && (cnt <= CW'(h_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            cnt        <= '0;
            s_q        <= '0;
            a_q        <= '0;
            r_q        <= '0;
            c_q        <= '0;
            h_q        <= '0;
            wr_q       <= 1'b0;
            en_q       <= 1'b0;
            rec_target <= '0;
            done       <= 1'b0;
            timeout    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase   <= PH_SETUP;
                        cnt     <= CW'(1);
                        s_q     <= setup_len;
                        a_q     <= act_len;
                        r_q     <= rec_len;
                        c_q     <= cyc_len;
                        h_q     <= hold_len;
                        wr_q    <= write_in;
                        en_q    <= iordy_en_in;
                        timeout <= 1'b0;
                    end
                end
                PH_SETUP: begin
                    if (cnt >= CW'(s_q)) begin
                        phase <= PH_ACTIVE;
                        cnt   <= CW'(1);
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PH_ACTIVE: begin
                    if (act_exit) begin
                        phase      <= PH_RECOV;
                        cnt        <= CW'(1);
                        rec_target <= rec_calc;
                        timeout    <= en_q && !iordy;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PH_RECOV: begin
                    if (cnt >= rec_target) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ata_pio_pin_drv.sv
module ata_pio_pin_drv
    import ata_pio_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  regsel_t       sel_in,
    input  logic [DW-1:0] wdata_in,
    input  logic          write_in,
    input  phase_e        phase,
    input  logic          hold_on,
    input  logic          strobe_rise,
    input  logic [DW-1:0] dd_in,
    output logic          cs0_n,
    output logic          cs1_n,
    output logic [2:0]    da,
    output logic          dior_n,
    output logic          diow_n,
    output logic [DW-1:0] dd_out,
    output logic          dd_oe,
    output logic [DW-1:0] rd_data
);

    regsel_t       sel_q;
    logic [DW-1:0] wdata_q;
    logic          wr_q;
    regsel_t       sel_out;
    logic          strobe_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= SEL_IDLE;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            rd_data <= '0;
        end else begin
            if (start) begin
                sel_q   <= sel_in;
                wdata_q <= wdata_in;
                wr_q    <= write_in;
            end
            // Capture on the read strobe's rising edge
            if (strobe_rise && !wr_q) rd_data <= dd_in;
        end
    end

    always_comb begin
        sel_out   = (phase == PH_IDLE) ? SEL_IDLE : sel_q;
        strobe_on = (phase == PH_ACTIVE);
        cs0_n     = sel_out.cs0_n;
        cs1_n     = sel_out.cs1_n;
        da        = sel_out.da;
        dior_n    = !(strobe_on && !wr_q);
        diow_n    = !(strobe_on && wr_q);
        dd_oe     = wr_q && (strobe_on || hold_on);
        dd_out    = dd_oe ? wdata_q : '0;
    end

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
    import ata_pio_pkg::*;
#(
    parameter int DW          = 16,
    parameter int TW          = 8,
    parameter int IORDY_FIRST = 2,
    parameter int IORDY_LIMIT = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_reg8,
    input  logic [4:0]    req_sel,
    input  logic [DW-1:0] req_wdata,
    input  logic          iordy_en,
    input  logic [2:0]    pio_mode,
    input  logic [TW-1:0] t_setup,
    input  logic [TW-1:0] t_act16,
    input  logic [TW-1:0] t_rec16,
    input  logic [TW-1:0] t_cyc16,
    input  logic [TW-1:0] t_act8,
    input  logic [TW-1:0] t_rec8,
    input  logic [TW-1:0] t_cyc8,
    output logic          busy,
    output logic          done,
    output logic          timeout,
    output logic [DW-1:0] rd_data,
    output logic          ata_cs0_n,
    output logic          ata_cs1_n,
    output logic [2:0]    ata_da,
    output logic          ata_dior_n,
    output logic          ata_diow_n,
    output logic [DW-1:0] dd_out,
    output logic          dd_oe,
    input  logic [DW-1:0] dd_in,
    input  logic          iordy
);

    localparam int LW = $clog2(IORDY_LIMIT + 1);
    localparam int CW = ((TW > LW) ? TW : LW) + 1;

    phase_e        phase;
    logic          start, hold_on, strobe_rise;
    logic [TW-1:0] setup_len, act_len, rec_len, cyc_len;
    logic [1:0]    hold_len;
    regsel_t       sel_in;

    assign busy   = (phase != PH_IDLE);
    assign start  = req_valid && !busy;
    assign sel_in = regsel_t'(req_sel);

    ata_pio_timing_sel #(.TW(TW)) i_tsel (
        .reg8      (req_reg8),
        .pio_mode  (pio_mode),
        .t_setup   (t_setup),
        .t_act16   (t_act16),
        .t_rec16   (t_rec16),
        .t_cyc16   (t_cyc16),
        .t_act8    (t_act8),
        .t_rec8    (t_rec8),
        .t_cyc8    (t_cyc8),
        .setup_len (setup_len),
        .act_len   (act_len),
        .rec_len   (rec_len),
        .cyc_len   (cyc_len),
        .hold_len  (hold_len)
    );

    ata_pio_phase_fsm #(
        .TW(TW), .FIRST(IORDY_FIRST), .LIMIT(IORDY_LIMIT), .CW(CW)
    ) i_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .write_in    (req_write),
        .iordy_en_in (iordy_en),
        .iordy       (iordy),
        .setup_len   (setup_len),
        .act_len     (act_len),
        .rec_len     (rec_len),
        .cyc_len     (cyc_len),
        .hold_len    (hold_len),
        .phase       (phase),
        .hold_on     (hold_on),
        .strobe_rise (strobe_rise),
        .done        (done),
        .timeout     (timeout)
    );

    ata_pio_pin_drv #(.DW(DW)) i_pins (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .sel_in      (sel_in),
        .wdata_in    (req_wdata),
        .write_in    (req_write),
        .phase       (phase),
        .hold_on     (hold_on),
        .strobe_rise (strobe_rise),
        .dd_in       (dd_in),
        .cs0_n       (ata_cs0_n),
        .cs1_n       (ata_cs1_n),
        .da          (ata_da),
        .dior_n      (ata_dior_n),
        .diow_n      (ata_diow_n),
        .dd_out      (dd_out),
        .dd_oe       (dd_oe),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/ata_pio_seq_chk.sv
module ata_pio_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       timeout,
    input logic       ata_cs0_n,
    input logic       ata_cs1_n,
    input logic [2:0] ata_da,
    input logic       ata_dior_n,
    input logic       ata_diow_n,
    input logic       dd_oe
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ata_cs0_n && ata_cs1_n && ata_dior_n && ata_diow_n && !dd_oe && ata_da == 3'd0));

    assert_sel_held_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable({ata_da, ata_cs1_n, ata_cs0_n}));

    assert_setup_before_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(ata_dior_n) || $fell(ata_diow_n)) |-> ($past(busy) && $past(ata_dior_n) && $past(ata_diow_n)));

    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ata_dior_n || ata_diow_n));

    assert_no_drive_on_read_R7: assert property (@(posedge clk) disable iff (rst)
        !ata_dior_n |-> !dd_oe);

    assert_timeout_at_release_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout) |-> ($rose(ata_dior_n) || $rose(ata_diow_n)));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind ata_pio_seq ata_pio_seq_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .timeout    (timeout),
    .ata_cs0_n  (ata_cs0_n),
    .ata_cs1_n  (ata_cs1_n),
    .ata_da     (ata_da),
    .ata_dior_n (ata_dior_n),
    .ata_diow_n (ata_diow_n),
    .dd_oe      (dd_oe)
);

// File: tb/test_ata_pio_seq.sv
module test_ata_pio_seq;

    localparam int FIRST = 2;
    localparam int LIMIT = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_reg8 = 1'b0;
    logic [4:0]  req_sel = '0;
    logic [15:0] req_wdata = '0;
    logic        iordy_en = 1'b0;
    logic [2:0]  pio_mode = '0;
    logic [7:0]  t_setup = 8'd1, t_act16 = 8'd1, t_rec16 = 8'd1, t_cyc16 = 8'd1;
    logic [7:0]  t_act8 = 8'd1, t_rec8 = 8'd1, t_cyc8 = 8'd1;
    logic        busy, done, timeout;
    logic [15:0] rd_data, dd_out, dd_in = '0;
    logic        ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, dd_oe;
    logic [2:0]  ata_da;
    logic        iordy = 1'b0;

    always #2 clk = ~clk;

    ata_pio_seq #(.DW(16), .TW(8), .IORDY_FIRST(FIRST), .IORDY_LIMIT(LIMIT)) i_ata_pio_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_reg8(req_reg8), .req_sel(req_sel), .req_wdata(req_wdata),
        .iordy_en(iordy_en), .pio_mode(pio_mode), .t_setup(t_setup),
        .t_act16(t_act16), .t_rec16(t_rec16), .t_cyc16(t_cyc16),
        .t_act8(t_act8), .t_rec8(t_rec8), .t_cyc8(t_cyc8),
        .busy(busy), .done(done), .timeout(timeout), .rd_data(rd_data),
        .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_da(ata_da),
        .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
        .dd_out(dd_out), .dd_oe(dd_oe), .dd_in(dd_in), .iordy(iordy)
    );

    typedef struct {
        logic        cs0, cs1;
        logic [2:0]  da;
        logic        rd_n, wr_n, oe;
        logic [15:0] dout;
        logic        busy, done, to;
        logic        wr;
        logic        chk_rd;
        logic [15:0] rd;
        string       tag;
    } exp_t;

    exp_t        q[$];
    exp_t        cur;
    int          n_chk = 0, n_err = 0;
    logic        mon_on = 1'b0;
    logic        exp_to = 1'b0;
    logic [15:0] exp_rd = '0;
    bit          finished = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference comparison, every falling edge
    always @(negedge clk) begin
        if (mon_on) begin
            if (q.size() > 0) begin
                cur = q.pop_front();
            end else begin
                cur = '{cs0: 1'b1, cs1: 1'b1, da: 3'd0, rd_n: 1'b1, wr_n: 1'b1, oe: 1'b0,
                        dout: '0, busy: 1'b0, done: 1'b0, to: exp_to, wr: 1'b0,
                        chk_rd: 1'b1, rd: exp_rd, tag: "R1"};
            end
            check({ata_da, ata_cs1_n, ata_cs0_n} == {cur.da, cur.cs1, cur.cs0}, "R2 select",
                  {27'd0, ata_da, ata_cs1_n, ata_cs0_n}, {27'd0, cur.da, cur.cs1, cur.cs0});
            check(ata_dior_n == cur.rd_n, cur.wr ? "R5 dior" : cur.tag, {31'd0, ata_dior_n}, {31'd0, cur.rd_n});
            check(ata_diow_n == cur.wr_n, cur.wr ? cur.tag : "R5 diow", {31'd0, ata_diow_n}, {31'd0, cur.wr_n});
            check(dd_oe == cur.oe, "R7 oe", {31'd0, dd_oe}, {31'd0, cur.oe});
            if (cur.oe) check(dd_out == cur.dout, "R7 dout", {16'd0, dd_out}, {16'd0, cur.dout});
            check(busy == cur.busy, "R11 busy", {31'd0, busy}, {31'd0, cur.busy});
            check(done == cur.done, "R11 done", {31'd0, done}, {31'd0, cur.done});
            check(timeout == cur.to, "R9 timeout", {31'd0, timeout}, {31'd0, cur.to});
            if (cur.chk_rd) check(rd_data == cur.rd, "R6 rd_data", {16'd0, rd_data}, {16'd0, cur.rd});
            if (cur.done) begin
                exp_to = cur.to;
                exp_rd = cur.rd;
            end
        end
    end

    // One bus cycle: build the expected trace, then drive IORDY and the bus
    task automatic do_txn(input bit wr, input bit reg8, input logic [4:0] sel,
                          input logic [15:0] wd, input logic [15:0] rv,
                          input bit en, input int hi_at, input logic [2:0] mode,
                          input bit poke);
        int s, a, c, rc, h, n, gap, r, total;
        bit to;
        exp_t e;
        string atag;
        @(negedge clk); #1;
        s  = (t_setup == 0) ? 1 : int'(t_setup);
        a  = reg8 ? int'(t_act8) : int'(t_act16);
        if (a == 0) a = 1;
        c  = reg8 ? int'(t_cyc8) : int'(t_cyc16);
        rc = reg8 ? int'(t_rec8) : int'(t_rec16);
        if (rc == 0) rc = 1;
        h  = (mode == 0) ? 3 : ((mode <= 2) ? 2 : 1);
        n  = a;
        while (en && !(n >= FIRST && n >= hi_at) && n < LIMIT) n++;
        to  = en && (n < hi_at);
        gap = (c > n) ? c - n : 0;
        r   = (gap > rc) ? gap : rc;
        if (wr && h > r) r = h;
        total = s + n + r + 1;
        atag = en ? "R8 active" : "R4 active";
        for (int k = 1; k <= total; k++) begin
            e = '{cs0: sel[0], cs1: sel[1], da: sel[4:2], rd_n: 1'b1, wr_n: 1'b1, oe: 1'b0,
                  dout: wd, busy: 1'b1, done: 1'b0, to: 1'b0, wr: wr, chk_rd: 1'b0,
                  rd: '0, tag: "R3 setup"};
            if (k > s && k <= s + n) begin
                e.rd_n = wr; e.wr_n = !wr; e.oe = wr; e.tag = atag;
            end else if (k > s + n && k < total) begin
                e.oe = wr && (k - (s + n) <= h); e.tag = "R10 recovery"; e.to = to;
            end else if (k == total) begin
                e.cs0 = 1'b1; e.cs1 = 1'b1; e.da = 3'd0; e.busy = 1'b0; e.done = 1'b1;
                e.to = to; e.chk_rd = 1'b1; e.rd = wr ? exp_rd_future(1'b1) : rv; e.tag = "R11 done";
            end
            q.push_back(e);
        end
        req_valid = 1'b1; req_write = wr; req_reg8 = reg8; req_sel = sel;
        req_wdata = wd; iordy_en = en; pio_mode = mode;
        iordy = en ? (s + 0 >= s + hi_at) : 1'b0;
        dd_in = ~rv;
        for (int k = 1; k <= total; k++) begin
            @(negedge clk); #1;
            req_valid = 1'b0;
            if (poke && k == 2) begin
                req_valid = 1'b1; req_write = !wr; req_sel = ~sel; req_wdata = ~wd;
            end
            iordy = en ? (k >= s + hi_at) : 1'b0;
            dd_in = (k == s + n) ? rv : ~rv;
        end
    endtask

    // Value rd_data should hold after a write: whatever the last read left
    function automatic logic [15:0] exp_rd_future(input bit dummy);
        logic [15:0] v;
        v = exp_rd;
        for (int i = 0; i < q.size(); i++) if (q[i].done) v = q[i].rd;
        return dummy ? v : v;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check(ata_cs0_n && ata_cs1_n && ata_dior_n && ata_diow_n, "R1 pins in reset",
              {28'd0, ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n}, 32'hF);
        check(!dd_oe && !busy && !done, "R1 oe/busy/done in reset",
              {29'd0, dd_oe, busy, done}, 32'd0);
        #1 rst = 1'b0;
        @(negedge clk);
        mon_on = 1'b1;

        // R2 R4 R6 R10: register read, cycle time dominates recovery
        t_setup = 8'd2; t_act8 = 8'd3; t_cyc8 = 8'd8; t_rec8 = 8'd2;
        t_act16 = 8'd4; t_cyc16 = 8'd6; t_rec16 = 8'd3;
        do_txn(1'b0, 1'b1, 5'b11110, 16'h0000, 16'hA55A, 1'b0, 0, 3'd0, 1'b0);
        // R7: data write, mode 0 hold of three
        do_txn(1'b1, 1'b0, 5'b00010, 16'h1234, 16'h0000, 1'b0, 0, 3'd0, 1'b0);
        // R7 R10: mode 4, minimum recovery
        t_rec16 = 8'd1; t_cyc16 = 8'd2;
        do_txn(1'b1, 1'b0, 5'b00010, 16'hBEEF, 16'h0000, 1'b0, 0, 3'd4, 1'b0);
        // R7 R10: mode 2, hold stretches recovery
        do_txn(1'b1, 1'b0, 5'b00110, 16'h00C3, 16'h0000, 1'b0, 0, 3'd2, 1'b0);
        // R3 R4: zero counts clamp to one, alternate status select
        t_setup = 8'd0; t_act8 = 8'd0; t_rec8 = 8'd0; t_cyc8 = 8'd0;
        do_txn(1'b0, 1'b1, 5'b11001, 16'h0000, 16'h7E81, 1'b0, 0, 3'd1, 1'b0);
        // R4: IORDY ignored when checking is off
        t_setup = 8'd1; t_act16 = 8'd3; t_cyc16 = 8'd5; t_rec16 = 8'd2;
        do_txn(1'b0, 1'b0, 5'b00010, 16'h0000, 16'h0F0F, 1'b0, 0, 3'd0, 1'b0);
        // R8: IORDY stretches a read to count 7
        t_act16 = 8'd2;
        do_txn(1'b0, 1'b0, 5'b00010, 16'h0000, 16'hC0DE, 1'b1, 7, 3'd3, 1'b0);
        // R8: IORDY high early, still not sampled before the first legal point
        t_act8 = 8'd1; t_cyc8 = 8'd3; t_rec8 = 8'd1;
        do_txn(1'b0, 1'b1, 5'b01110, 16'h0000, 16'h3C3C, 1'b1, 0, 3'd4, 1'b0);
        // R9: device never ready, on a write
        do_txn(1'b1, 1'b0, 5'b00010, 16'h5A5A, 16'h0000, 1'b1, 1000, 3'd1, 1'b0);
        // R9: next accepted request clears the flag; R11: request during busy ignored
        do_txn(1'b0, 1'b1, 5'b10010, 16'h0000, 16'h9009, 1'b0, 0, 3'd0, 1'b1);
        // R8 R10: stretched write whose active count exceeds the cycle time
        t_cyc16 = 8'd4; t_rec16 = 8'd1;
        do_txn(1'b1, 1'b0, 5'b00010, 16'hF00D, 16'h0000, 1'b1, 5, 3'd3, 1'b1);
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL R11 watchdog expired act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule